// File: doc/BRIEF.md
# Wake-up timer with compare channels

A 32-bit up-counter for low-power tick and alarm generation. One of four clock-enable strobes, chosen in the control register, drives a prescaler. The prescaler in turn advances the counter while counting is enabled. Four compare channels, named A to D, each raise a sticky status flag when the counter meets their value. A fifth flag marks a wrap through zero. Any flag whose enable bit is set drives the single interrupt output.

Software reaches every 32-bit quantity as two 16-bit words. To read the count coherently, software sets the freeze bit, reads both halves of a held snapshot, and clears the bit again. In periodic mode, channel A sets the period by reloading the counter to zero. An optional stop request makes the timer disarm itself on the channel A match.

Top module: `wake_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, `irq` is low and `bus_rdata` is zero.
- R2: Control bits [1:0] choose the prescale ratio: 0 gives 4, 1 gives 16, 2 gives 256 and 3 gives 32768 strobes of the selected source per count. Counting happens only while control bit 7 is 1. While bit 7 is 0 the prescaler is held at zero.
- R3: Control bits [10:9] pick which `src_stb` bit feeds the prescaler, by its index.
- R4: The count sits at word 0 (bits 15:0) and word 1 (bits 31:16). A write to either word loads that half, and the write takes priority over counting in the same cycle. Word 3 is a plain 16-bit read/write register.
- R5: Channel A sits at words 15 and 16, B at 4 and 5, C at 6 and 7, and D at 8 and 9, each as a low and high pair. On a count step where the count equals a channel's value, status bit 0, 1, 2 or 3 (for A, B, C, D) is set.
- R6: A count step taken at 0xFFFFFFFF sets status bit 4 (rollover), and the count becomes 0.
- R7: When control bit 6 is 0 (periodic mode), a count step that matches channel A loads the count with 0. When bit 6 is 1 (free-running), the count increments and wraps.
- R8: When control bit 11 is 1, a count step that matches channel A clears control bit 7 and leaves the count at the matched value.
- R9: While control bit 3 (freeze) is 1, words 0 and 1 return the count captured in the cycle the freeze bit was written. Status bit 7 reads the freeze bit.
- R10: `irq` is registered. In each cycle it equals the OR, taken one cycle earlier, of status bits [4:0] AND the enable register (word 10, same bit positions).
- R11: Writing word 12 clears each status bit [4:0] whose data bit is 1. A flag set in the same cycle as a clear stays set. Word 12 reads zero.
- R12: `bus_rdata` returns the word at `bus_addr`, registered, one cycle after the address is presented. Word 2 returns the control bits, word 11 the status, and unused words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_stb | input | 4 | Clock-enable strobes, one per clock source |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads a sweep of addresses across every word while the counter runs, so any difference in the count, the flags or the control state shows up within one sweep. The sources toggle at distinct rates (every cycle, and every second, third and fifth cycle), so a wrong source index or a wrong prescale ratio shows up as a wrong count slope. Separate runs then cover the following:
- channel values placed ahead of the count, which tells the four flag positions apart;
- a preload just below the wrap, which exercises rollover;
- periodic reloads overlapped with a clear written every cycle, which tests that a set wins over a simultaneous clear;
- a stop-on-match run, checked against the absolute held value;
- a frozen read taken while the live count keeps moving.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 16;

  localparam logic [AW-1:0] A_CNT_LO = 5'd0;
  localparam logic [AW-1:0] A_CNT_HI = 5'd1;
  localparam logic [AW-1:0] A_CTRL   = 5'd2;
  localparam logic [AW-1:0] A_INC    = 5'd3;
  localparam logic [AW-1:0] A_IEN    = 5'd10;
  localparam logic [AW-1:0] A_STA    = 5'd11;
  localparam logic [AW-1:0] A_CLR    = 5'd12;

  localparam int C_FRZ  = 3;
  localparam int C_FREE = 6;
  localparam int C_RUN  = 7;
  localparam int C_SRC  = 9;
  localparam int C_STOP = 11;
  localparam logic [11:0] CTRL_MASK = 12'hECB;

  typedef enum logic [1:0] {DIV_4, DIV_16, DIV_256, DIV_32K} div_e;

  function automatic logic [14:0] div_last(logic [1:0] code);
    case (div_e'(code))
      DIV_4:   return 15'd3;
      DIV_16:  return 15'd15;
      DIV_256: return 15'd255;
      default: return 15'd32767;
    endcase
  endfunction

  // channel 0 (A) sits after the reserved words; B..D follow the increment word
  function automatic logic [AW-1:0] cmp_addr(int ch, logic hi);
    logic [AW-1:0] base;
    base = (ch == 0) ? 5'd15 : AW'(4 + 2 * (ch - 1));
    return base + {4'd0, hi};
  endfunction
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int NSRC = 4,
  parameter int PW   = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [$clog2(NSRC)-1:0] src_sel,
  input  logic [NSRC-1:0]         src_stb,
  input  logic [1:0]              div_code,
  output logic                    tick
);
  import wt_pkg::*;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;
  logic          stb;

  assign last = PW'(div_last(div_code));
  assign stb  = src_stb[src_sel];
  assign tick = run && stb && (pre_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (stb) begin
      pre_q <= (pre_q >= last) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wt_match.sv
module wt_match #(
  parameter int CW  = 32,
  parameter int NCH = 4
) (
  input  logic [CW-1:0]     cnt,
  input  logic [NCH*CW-1:0] cmp_flat,
  output logic [NCH-1:0]    hit
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    assign hit[ch] = (cnt == cmp_flat[ch*CW +: CW]);
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            reload,
  input  logic            hold,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [CW/2-1:0] ld_val,
  output logic [CW-1:0]   cnt_q,
  output logic            at_max
);
  localparam int HW = CW / 2;

  logic [CW-1:0] nxt;

  assign at_max = &cnt_q;

  always_comb begin
    nxt = cnt_q;
    if (tick && !hold) begin
      nxt = reload ? '0 : cnt_q + 1'b1;
    end
    if (ld_lo) nxt[HW-1:0]  = ld_val;
    if (ld_hi) nxt[CW-1:HW] = ld_val;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CW   = 32,
  parameter int NCH  = 4,
  parameter int NSRC = 4,
  parameter int PW   = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [wt_pkg::AW-1:0]  bus_addr,
  input  logic [wt_pkg::DW-1:0]  bus_wdata,
  output logic [wt_pkg::DW-1:0]  bus_rdata,
  input  logic [NSRC-1:0]        src_stb,
  output logic                   irq
);
  import wt_pkg::*;

  localparam int HW   = CW / 2;
  localparam int NFLG = NCH + 1;
  localparam int SW   = $clog2(NSRC);

  logic [11:0]     ctrl_q;
  logic [NFLG-1:0] ien_q;
  logic [NFLG-1:0] sta_q;
  logic [HW-1:0]   inc_q;
  logic [CW-1:0]   cmp_q [NCH];
  logic [NCH*CW-1:0] cmp_flat;
  logic [CW-1:0]   snap_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_view;
  logic            at_max;
  logic [NCH-1:0]  hit;
  logic            tick;
  logic            stop_a;
  logic            reload;
  logic [NFLG-1:0] set_vec;
  logic [NFLG-1:0] clr_vec;
  logic [DW-1:0]   rd_mux;

  function automatic logic wsel(logic [AW-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  wt_prescaler #(.NSRC(NSRC), .PW(PW)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q[C_RUN]),
    .src_sel  (ctrl_q[C_SRC +: SW]),
    .src_stb  (src_stb),
    .div_code (ctrl_q[1:0]),
    .tick     (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_flat
    assign cmp_flat[ch*CW +: CW] = cmp_q[ch];
  end

  wt_match #(.CW(CW), .NCH(NCH)) u_match (
    .cnt      (cnt_q),
    .cmp_flat (cmp_flat),
    .hit      (hit)
  );

  assign stop_a = tick && hit[0] && ctrl_q[C_STOP];
  assign reload = !ctrl_q[C_FREE] && hit[0];

  wt_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .reload (reload),
    .hold   (stop_a),
    .ld_lo  (wsel(A_CNT_LO)),
    .ld_hi  (wsel(A_CNT_HI)),
    .ld_val (bus_wdata[HW-1:0]),
    .cnt_q  (cnt_q),
    .at_max (at_max)
  );

  assign set_vec = tick ? {at_max, hit} : '0;
  assign clr_vec = wsel(A_CLR) ? bus_wdata[NFLG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wsel(A_CTRL)) begin
      ctrl_q <= bus_wdata[11:0] & CTRL_MASK;
    end else if (stop_a) begin
      ctrl_q[C_RUN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      inc_q  <= '0;
      sta_q  <= '0;
      snap_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wsel(A_IEN)) ien_q <= bus_wdata[NFLG-1:0];
      if (wsel(A_INC)) inc_q <= bus_wdata[HW-1:0];
      sta_q <= (sta_q & ~clr_vec) | set_vec;
      if (!ctrl_q[C_FRZ]) snap_q <= cnt_q;
      irq <= |(sta_q & ien_q);
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmpreg
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[ch] <= '0;
      end else begin
        if (wsel(cmp_addr(ch, 1'b0))) cmp_q[ch][HW-1:0]  <= bus_wdata[HW-1:0];
        if (wsel(cmp_addr(ch, 1'b1))) cmp_q[ch][CW-1:HW] <= bus_wdata[HW-1:0];
      end
    end
  end

  assign cnt_view = ctrl_q[C_FRZ] ? snap_q : cnt_q;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CNT_LO: rd_mux = cnt_view[HW-1:0];
      A_CNT_HI: rd_mux = cnt_view[CW-1:HW];
      A_CTRL:   rd_mux = DW'(ctrl_q);
      A_INC:    rd_mux = inc_q;
      A_IEN:    rd_mux = DW'(ien_q);
      A_STA:    rd_mux = DW'({ctrl_q[C_FRZ], 2'b00, sta_q});
      default:  rd_mux = '0;
    endcase
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == cmp_addr(ch, 1'b0)) rd_mux = cmp_q[ch][HW-1:0];
      if (bus_addr == cmp_addr(ch, 1'b1)) rd_mux = cmp_q[ch][CW-1:HW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/wt_chk.sv
module wt_chk #(
  parameter int CW   = 32,
  parameter int NFLG = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            hit_a,
  input logic            hit_b,
  input logic            at_max,
  input logic            run,
  input logic            frz,
  input logic            free,
  input logic            stopa,
  input logic [NFLG-1:0] sta_q,
  input logic [NFLG-1:0] ien_q,
  input logic            irq,
  input logic [CW-1:0]   snap_q,
  input logic [CW-1:0]   cnt_q,
  input logic            bus_we,
  input logic [4:0]      bus_addr
);
  logic cnt_wr;
  logic ctrl_wr;
  assign cnt_wr  = bus_we && (bus_addr == 5'd0 || bus_addr == 5'd1);
  assign ctrl_wr = bus_we && (bus_addr == 5'd2);

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  // R6
  rollover_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && at_max) |=> sta_q[4]);

  // R7
  periodic_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !free && hit_a && !stopa && !cnt_wr) |=> (cnt_q == '0));

  // R8
  stop_on_a_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hit_a && stopa && !ctrl_wr) |=> !run);

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frz && $past(frz)) |-> $stable(snap_q));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(sta_q) & $past(ien_q))));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hit_b) |=> sta_q[1]);
endmodule

bind wake_timer wt_chk #(.CW(CW), .NFLG(NCH + 1)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .hit_a    (hit[0]),
  .hit_b    (hit[1]),
  .at_max   (at_max),
  .run      (ctrl_q[7]),
  .frz      (ctrl_q[3]),
  .free     (ctrl_q[6]),
  .stopa    (ctrl_q[11]),
  .sta_q    (sta_q),
  .ien_q    (ien_q),
  .irq      (irq),
  .snap_q   (snap_q),
  .cnt_q    (cnt_q),
  .bus_we   (bus_we),
  .bus_addr (bus_addr)
);

// File: tb/sim_wake_timer.sv
`timescale 1ns/1ps
module sim_wake_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  src_stb = '0;
  logic        irq;

  always #10 clk = ~clk;

  wake_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_stb(src_stb), .irq(irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    wd = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R1";
  logic [4:0] sweep = '0;

  // behavioural reference state
  logic [31:0] m_cnt, m_snap, m_cmp[4];
  logic [11:0] m_ctrl;
  logic [4:0]  m_ien, m_sta;
  logic [15:0] m_inc, m_rdata;
  logic        m_irq;
  int          m_pre;

  // temporaries of the model
  logic [31:0] t_cnt, t_view;
  logic [11:0] t_ctrl;
  logic [4:0]  t_sta, t_set;
  logic [15:0] t_rd;
  int          t_pre, t_last, a;
  bit          t_tick;

  function automatic int last_of(logic [1:0] c);
    case (c)
      2'd0: return 3;
      2'd1: return 15;
      2'd2: return 255;
      default: return 32767;
    endcase
  endfunction

  function automatic int ch_of(int ad);
    if (ad == 15 || ad == 16) return 0;
    if (ad >= 4 && ad <= 9) return (ad - 4) / 2 + 1;
    return -1;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = 0; m_snap = 0; m_ctrl = 0; m_ien = 0; m_sta = 0; m_inc = 0;
      m_rdata = 0; m_irq = 0; m_pre = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    end else begin
      a = int'(bus_addr);
      t_view = m_ctrl[3] ? m_snap : m_cnt;
      t_rd = 0;
      if (a == 0) t_rd = t_view[15:0];
      else if (a == 1) t_rd = t_view[31:16];
      else if (a == 2) t_rd = {4'd0, m_ctrl};
      else if (a == 3) t_rd = m_inc;
      else if (a == 10) t_rd = {11'd0, m_ien};
      else if (a == 11) t_rd = {8'd0, m_ctrl[3], 2'b00, m_sta};
      else if (ch_of(a) >= 0) t_rd = ((a % 2) == (a >= 15 ? 1 : 0)) ?
                                     m_cmp[ch_of(a)][15:0] : m_cmp[ch_of(a)][31:16];
      t_last = last_of(m_ctrl[1:0]);
      t_tick = 0;
      t_pre = m_pre;
      if (!m_ctrl[7]) t_pre = 0;
      else if (src_stb[m_ctrl[10:9]]) begin
        if (m_pre >= t_last) begin t_tick = 1; t_pre = 0; end
        else t_pre = m_pre + 1;
      end
      t_cnt = m_cnt; t_ctrl = m_ctrl; t_set = 0;
      if (t_tick) begin
        for (int i = 0; i < 4; i++) t_set[i] = (m_cnt == m_cmp[i]);
        t_set[4] = (m_cnt == 32'hFFFF_FFFF);
        if (m_ctrl[11] && t_set[0]) t_ctrl[7] = 1'b0;
        else if (!m_ctrl[6] && t_set[0]) t_cnt = 0;
        else t_cnt = m_cnt + 1;
      end
      t_sta = m_sta;
      if (bus_we && a == 12) t_sta = t_sta & ~bus_wdata[4:0];
      t_sta = t_sta | t_set;
      m_irq = |(m_sta & m_ien);
      if (!m_ctrl[3]) m_snap = m_cnt;
      if (bus_we) begin
        if (a == 0) t_cnt[15:0] = bus_wdata;
        if (a == 1) t_cnt[31:16] = bus_wdata;
        if (a == 2) t_ctrl = bus_wdata[11:0] & 12'hECB;
        if (a == 3) m_inc = bus_wdata;
        if (a == 10) m_ien = bus_wdata[4:0];
        if (ch_of(a) >= 0) begin
          if ((a % 2) == (a >= 15 ? 1 : 0)) m_cmp[ch_of(a)][15:0] = bus_wdata;
          else m_cmp[ch_of(a)][31:16] = bus_wdata;
        end
      end
      m_rdata = t_rd; m_cnt = t_cnt; m_ctrl = t_ctrl; m_sta = t_sta; m_pre = t_pre;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (bus_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s rdata act=%h exp=%h cyc=%0d", tag, bus_rdata, m_rdata, cyc);
      end
      n_chk++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL R10 irq act=%b exp=%b cyc=%0d", irq, m_irq, cyc);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp<190000", wd);
      finish_run();
    end
  end

  task automatic step(bit we, logic [4:0] ad, logic [15:0] d);
    @(negedge clk);
    cyc++;
    src_stb = {cyc % 5 == 0, cyc % 3 == 0, cyc % 2 == 0, 1'b1};
    bus_we = we; bus_addr = ad; bus_wdata = d;
  endtask

  task automatic wr(logic [4:0] ad, logic [15:0] d);
    step(1'b1, ad, d);
  endtask

  // R12 sweep: every word is read back while the timer runs
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      sweep = (sweep >= 5'd16) ? 5'd0 : sweep + 5'd1;
      step(1'b0, sweep, 16'h0);
    end
  endtask

  task automatic rd_chk(logic [4:0] ad, logic [15:0] exp, string rq);
    step(1'b0, ad, 16'h0);
    @(posedge clk); #2;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s word %0d act=%h exp=%h", rq, ad, bus_rdata, exp);
    end
  endtask

  initial begin
    repeat (3) step(1'b0, 5'd0, 16'h0);
    rst = 1'b0;
    // R1 reset state, absolute
    rd_chk(5'd2, 16'h0000, "R1");
    rd_chk(5'd11, 16'h0000, "R1");
    tag = "R12"; idle(34);
    // R4 count halves and increment word
    tag = "R4";
    wr(5'd0, 16'h1234); wr(5'd1, 16'hABCD); wr(5'd3, 16'h5A5A);
    rd_chk(5'd1, 16'hABCD, "R4");
    idle(20);
    // R2 R3 ratios and sources, free-running
    tag = "R3";
    wr(5'd2, 16'h00C0); idle(60);
    wr(5'd2, 16'h02C0); idle(60);
    wr(5'd2, 16'h04C0); idle(60);
    wr(5'd2, 16'h06C0); idle(80);
    tag = "R2";
    wr(5'd2, 16'h00C1); idle(200);
    wr(5'd2, 16'h00C2); idle(1500);
    wr(5'd2, 16'h00C3); idle(70000);
    wr(5'd2, 16'h0040); idle(30);
    // R5 match flags with interrupt enables
    tag = "R5";
    wr(5'd0, 16'h0); wr(5'd1, 16'h0);
    wr(5'd15, 16'h0030); wr(5'd16, 16'h0);
    wr(5'd4, 16'h0005); wr(5'd5, 16'h0);
    wr(5'd6, 16'h0009); wr(5'd7, 16'h0);
    wr(5'd8, 16'h0010); wr(5'd9, 16'h0);
    wr(5'd10, 16'h001F);
    wr(5'd2, 16'h00C0); idle(300);
    rd_chk(5'd11, 16'h000F, "R5");
    tag = "R11"; wr(5'd12, 16'h001F); idle(10);
    // R6 rollover
    tag = "R6";
    wr(5'd2, 16'h0040); wr(5'd1, 16'hFFFF); wr(5'd0, 16'hFFFD);
    wr(5'd2, 16'h00C0); idle(40);
    // R7 periodic reload on A
    tag = "R7";
    wr(5'd2, 16'h0000); wr(5'd12, 16'h001F);
    wr(5'd0, 16'h0); wr(5'd1, 16'h0); wr(5'd15, 16'h0007);
    wr(5'd4, 16'h0003);
    wr(5'd2, 16'h0080); idle(200);
    // R11 clear every cycle while B keeps matching
    tag = "R11";
    for (int i = 0; i < 60; i++) wr(5'd12, 16'h001F);
    idle(40);
    // R8 stop on channel A
    tag = "R8";
    wr(5'd2, 16'h0000); wr(5'd12, 16'h001F);
    wr(5'd0, 16'h0); wr(5'd15, 16'h0014);
    wr(5'd2, 16'h08C0); idle(150);
    rd_chk(5'd0, 16'h0014, "R8");
    rd_chk(5'd2, 16'h0840, "R8");
    // R9 freeze
    tag = "R9";
    wr(5'd1, 16'h0001); wr(5'd2, 16'h00C0); idle(30);
    wr(5'd2, 16'h00C8); idle(120);
    wr(5'd2, 16'h00C0); idle(40);
    tag = "R1"; rst = 1'b1; idle(3); rst = 1'b0; idle(20);
    finish_run();
  end
endmodule